// File: doc/BRIEF.md
# Hot-Insert Connection Sequencer

This block decides when the upstream (backplane) and downstream (card) segments of a two-wire serial bus may be joined after a card is plugged into a live system, and it reports when the join has been made. It watches the clock and data lines of both segments and joins them only at a transaction boundary. A boundary is either both segments quiet, or one segment closing its transfer with a stop while the other is quiet. The switch, precharge source and rise-time boosters are analog circuits outside this block. The block drives only their control levels.

The block starts in lockout while the supply is not yet good. During lockout it asks for precharge and ignores all bus activity. Once the supply is good and the enable level is high, the block waits out a settling delay and then looks for a boundary. Precharge is dropped at the first join and returns only when the supply is lost again. Enable low or a stuck-bus fault from the neighbouring recovery block breaks the join straight away. When the fault clears, the block looks for a new boundary before it joins again. The rise-time boosters are allowed only while the segments are joined and no fault is present.

Top module: `hot_insert_seq`

## Requirements
- R1: While `pwr_good` is low, `link_en` is 0, `precharge_en` is 1 and `ready_pull` is 1, and stops or idle periods seen on either segment during that time do not count toward a later join.
- R2: After lockout, with `enable` high and the settling delay over, the segments join only when both sides are idle, or one side shows a stop while the other is idle; a stop on one side while the other side is busy does not join them.
- R3: A side is idle once both of its synchronised lines have been sampled high on `IDLE_CYCLES` consecutive clocks; any low sample on either line of that side restarts the count.
- R4: `precharge_en` goes to 0 at the first join and stays 0 through enable changes, faults and rejoins until `pwr_good` goes low again.
- R5: `enable` sampled low drops `link_en` to 0 and sets `ready_pull` to 1 from the next clock edge.
- R6: After `enable` rises, no join happens until `ENA_DELAY_CYCLES` clocks have passed; with both sides already idle, the join follows one to two clocks after that.
- R7: `ready_pull` (1 = pull the open-drain ready line low) is 0 only while the segments are joined; `stuck_fault` high breaks the join and sets `ready_pull` from the next clock edge.
- R8: After `stuck_fault` falls, the block does not rejoin until a new idle or stop boundary, as defined in R2, is seen.
- R9: `accel_en` is 1 only while the segments are joined and `stuck_fault` is low; it drops in the same cycle that `stuck_fault` rises.
- R10: A stop is a rise of SDA between two consecutive synchronised samples while SCL is high in both samples; each bus line passes through a two-flop synchroniser, so a stop at the pins joins the segments on the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply above lockout threshold |
| enable | input | 1 | Connection enable level |
| stuck_fault | input | 1 | Stuck-bus fault from the recovery block |
| up_scl | input | 1 | Upstream clock line sample |
| up_sda | input | 1 | Upstream data line sample |
| dn_scl | input | 1 | Downstream clock line sample |
| dn_sda | input | 1 | Downstream data line sample |
| link_en | output | 1 | Join the two segments |
| precharge_en | output | 1 | Enable the line precharge source |
| ready_pull | output | 1 | Pull the open-drain ready line low |
| accel_en | output | 1 | Enable rise-time boosters |

## Verification
The control inputs `pwr_good`, `enable` and `stuck_fault` act on the outputs from the next clock edge. The exception is `accel_en`, which drops in the same cycle as `stuck_fault`. The bench samples these outputs one cycle after driving an input, and checks `accel_en` a moment after the fault is raised. A stop at the bus pins joins the segments on the third edge, so the bench checks one cycle after the stop that no join has happened yet, and four cycles after it that the join is made. Idle joins and the enable delay take their own counted windows, so the bench checks a few cycles before the earliest legal join that none has occurred, and a few cycles after the latest that one has.

// File: rtl/hsq_pkg.sv
`timescale 1ns/1ps
package hsq_pkg;

    typedef enum logic [2:0] {
        ST_LOCK    = 3'd0,
        ST_WAIT_EN = 3'd1,
        ST_EN_DLY  = 3'd2,
        ST_ARMED   = 3'd3,
        ST_LINK    = 3'd4,
        ST_FAULT   = 3'd5
    } hsq_state_e;

    typedef struct packed {
        logic idle;
        logic stop;
    } hsq_side_t;

    localparam int HSQ_SIDES = 2;

    // Transaction boundary: both quiet, or one closes with a stop while the other is quiet.
    function automatic logic hsq_safe(input hsq_side_t a, input hsq_side_t b);
        return (a.idle & b.idle) | (a.stop & b.idle) | (b.stop & a.idle);
    endfunction

endpackage

// File: rtl/hsq_sync.sv
`timescale 1ns/1ps
module hsq_sync #(
    parameter int          WIDTH     = 4,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RESET_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/hsq_side_mon.sv
`timescale 1ns/1ps
module hsq_side_mon
    import hsq_pkg::*;
#(
    parameter int IDLE_CYCLES = 19000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      scl,
    input  logic      sda,
    output hsq_side_t flags
);

    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] IDLE_LIM = CW'(IDLE_CYCLES);

    typedef struct packed {
        logic          scl_p;
        logic          sda_p;
        logic [CW-1:0] cnt;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d       = mon_q;
        mon_d.scl_p = scl;
        mon_d.sda_p = sda;
        if (clr || !(scl && sda)) begin
            mon_d.cnt = '0;
        end else if (mon_q.cnt != IDLE_LIM) begin
            mon_d.cnt = mon_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '{scl_p: 1'b1, sda_p: 1'b1, cnt: '0};
        end else begin
            mon_q <= mon_d;
        end
    end

    assign flags.idle = !clr && (mon_q.cnt == IDLE_LIM);
    assign flags.stop = !clr && scl && mon_q.scl_p && sda && !mon_q.sda_p;

endmodule

// File: rtl/hsq_ctrl.sv
`timescale 1ns/1ps
module hsq_ctrl
    import hsq_pkg::*;
#(
    parameter int ENA_DELAY_CYCLES = 19000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwr_good,
    input  logic      enable,
    input  logic      stuck_fault,
    input  hsq_side_t up_f,
    input  hsq_side_t dn_f,
    output logic      link_en,
    output logic      precharge_en,
    output logic      ready_pull,
    output logic      accel_en
);

    localparam int DW = $clog2(ENA_DELAY_CYCLES + 1);
    localparam logic [DW-1:0] DLY_LIM = DW'(ENA_DELAY_CYCLES - 1);

    typedef struct packed {
        hsq_state_e    st;
        logic [DW-1:0] dly;
        logic          pre;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  safe;

    assign safe = hsq_safe(up_f, dn_f);

    always_comb begin
        ctl_d = ctl_q;
        if (!pwr_good) begin
            ctl_d.st  = ST_LOCK;
            ctl_d.pre = 1'b1;
            ctl_d.dly = '0;
        end else if (!enable) begin
            ctl_d.st  = ST_WAIT_EN;
            ctl_d.dly = '0;
        end else if (stuck_fault) begin
            ctl_d.st = ST_FAULT;
        end else begin
            unique case (ctl_q.st)
                ST_LOCK: ctl_d.st = ST_WAIT_EN;
                ST_WAIT_EN: begin
                    ctl_d.st  = ST_EN_DLY;
                    ctl_d.dly = '0;
                end
                ST_EN_DLY: begin
                    if (ctl_q.dly == DLY_LIM) begin
                        ctl_d.st = ST_ARMED;
                    end else begin
                        ctl_d.dly = ctl_q.dly + 1'b1;
                    end
                end
                ST_ARMED: begin
                    if (safe) begin
                        ctl_d.st  = ST_LINK;
                        ctl_d.pre = 1'b0;
                    end
                end
                ST_LINK:  ctl_d.st = ST_LINK;
                ST_FAULT: ctl_d.st = ST_ARMED;
                default:  ctl_d.st = ST_LOCK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_LOCK, dly: '0, pre: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign link_en      = (ctl_q.st == ST_LINK);
    assign ready_pull   = (ctl_q.st != ST_LINK);
    assign precharge_en = ctl_q.pre;
    assign accel_en     = link_en && !stuck_fault;

endmodule

// File: rtl/hot_insert_seq.sv
`timescale 1ns/1ps
module hot_insert_seq
    import hsq_pkg::*;
#(
    parameter int IDLE_CYCLES      = 19000,
    parameter int ENA_DELAY_CYCLES = 19000,
    parameter int SYNC_STAGES      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic enable,
    input  logic stuck_fault,
    input  logic up_scl,
    input  logic up_sda,
    input  logic dn_scl,
    input  logic dn_sda,
    output logic link_en,
    output logic precharge_en,
    output logic ready_pull,
    output logic accel_en
);

    localparam int LINES = 2 * HSQ_SIDES;

    logic [LINES-1:0]     pins_raw;
    logic [LINES-1:0]     pins_s;
    logic [HSQ_SIDES-1:0] scl_s;
    logic [HSQ_SIDES-1:0] sda_s;
    hsq_side_t            side_f [HSQ_SIDES];

    // Bit layout per side k: clock at 2k+1, data at 2k; side 0 upstream, side 1 downstream.
    assign pins_raw = {dn_scl, dn_sda, up_scl, up_sda};

    hsq_sync #(
        .WIDTH     (LINES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({LINES{1'b1}})
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    for (genvar k = 0; k < HSQ_SIDES; k++) begin : g_side
        assign scl_s[k] = pins_s[2*k+1];
        assign sda_s[k] = pins_s[2*k];

        hsq_side_mon #(
            .IDLE_CYCLES (IDLE_CYCLES)
        ) mon_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (!pwr_good),
            .scl   (scl_s[k]),
            .sda   (sda_s[k]),
            .flags (side_f[k])
        );
    end

    hsq_ctrl #(
        .ENA_DELAY_CYCLES (ENA_DELAY_CYCLES)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_good     (pwr_good),
        .enable       (enable),
        .stuck_fault  (stuck_fault),
        .up_f         (side_f[0]),
        .dn_f         (side_f[1]),
        .link_en      (link_en),
        .precharge_en (precharge_en),
        .ready_pull   (ready_pull),
        .accel_en     (accel_en)
    );

endmodule

// File: rtl/hot_insert_seq_chk.sv
`timescale 1ns/1ps
module hot_insert_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic enable,
    input logic stuck_fault,
    input logic link_en,
    input logic precharge_en,
    input logic ready_pull,
    input logic accel_en
);

    AST_LOCK_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !link_en); // R1

    AST_LOCK_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> precharge_en); // R1

    AST_PRECHARGE_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !precharge_en) |=> !precharge_en); // R4

    AST_LINK_NO_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |-> !precharge_en); // R4

    AST_ENABLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!link_en && ready_pull)); // R5

    AST_FAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_fault |=> (!link_en && ready_pull)); // R7

    AST_READY_ONLY_LINKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_pull |-> link_en); // R7

    AST_ACCEL_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_fault |-> !accel_en); // R9

    AST_ACCEL_ONLY_LINKED: assert property (@(posedge clk) disable iff (!rst_n)
        accel_en |-> link_en); // R9

endmodule

bind hot_insert_seq hot_insert_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .enable       (enable),
    .stuck_fault  (stuck_fault),
    .link_en      (link_en),
    .precharge_en (precharge_en),
    .ready_pull   (ready_pull),
    .accel_en     (accel_en)
);

// File: tb/hot_insert_seq_tb_top.sv
`timescale 1ns/1ps
module hot_insert_seq_tb_top;

    localparam int IDLE_N = 32;
    localparam int DLY_N  = 20;

    logic clk = 1'b0;
    logic rst_n, pwr_good, enable, stuck_fault;
    logic up_scl, up_sda, dn_scl, dn_sda;
    logic link_en, precharge_en, ready_pull, accel_en;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hot_insert_seq #(
        .IDLE_CYCLES      (IDLE_N),
        .ENA_DELAY_CYCLES (DLY_N)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_good     (pwr_good),
        .enable       (enable),
        .stuck_fault  (stuck_fault),
        .up_scl       (up_scl),
        .up_sda       (up_sda),
        .dn_scl       (dn_scl),
        .dn_sda       (dn_sda),
        .link_en      (link_en),
        .precharge_en (precharge_en),
        .ready_pull   (ready_pull),
        .accel_en     (accel_en)
    );

    // Expected values from the requirements
    function automatic logic exp_pull(input logic linked);
        return !linked;                          // R7
    endfunction

    function automatic logic exp_accel(input logic linked, input logic flt);
        return linked && !flt;                   // R9
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input logic lk, input logic pre);
        check(req, "link_en", link_en, lk);
        check(req, "precharge_en", precharge_en, pre);
        check(req, "ready_pull", ready_pull, exp_pull(lk));
        check(req, "accel_en", accel_en, exp_accel(lk, stuck_fault));
    endtask

    task automatic stop_on(input bit dn_side);
        if (dn_side) begin dn_scl = 1'b0; dn_sda = 1'b0; end
        else         begin up_scl = 1'b0; up_sda = 1'b0; end
        cyc(2);
        if (dn_side) dn_scl = 1'b1; else up_scl = 1'b1;
        cyc(3);
        if (dn_side) dn_sda = 1'b1; else up_sda = 1'b1;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4307));
        rst_n = 1'b0; pwr_good = 1'b0; enable = 1'b1; stuck_fault = 1'b0;
        up_scl = 1'b1; up_sda = 1'b1; dn_scl = 1'b1; dn_sda = 1'b1;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        check_outs("R1 reset", 1'b0, 1'b1);

        // R1: activity and stops during lockout are ignored
        for (int i = 0; i < 4; i++) begin
            stop_on(i[0]);
            cyc(10);
        end
        cyc(40);
        check_outs("R1 lockout", 1'b0, 1'b1);

        // R3 / R4: power good with idle buses; idle count starts only now
        pwr_good = 1'b1;
        cyc(30);
        check("R3 idle not yet", "link_en", link_en, 1'b0);
        cyc(10);
        check_outs("R4 first link", 1'b1, 1'b0);

        // R5: enable low
        enable = 1'b0;
        cyc(1);
        check_outs("R5 enable low", 1'b0, 1'b0);

        // R6: enable delay with idle buses
        cyc(3);
        enable = 1'b1;
        cyc(DLY_N);
        check("R6 delay", "link_en", link_en, 1'b0);
        cyc(4);
        check("R6 after delay", "link_en", link_en, 1'b1);

        // R2 / R10: upstream busy, downstream idle, then upstream stop
        enable = 1'b0; cyc(1);
        up_scl = 1'b0;
        enable = 1'b1;
        cyc(100);
        check("R2 busy side", "link_en", link_en, 1'b0);
        up_sda = 1'b0; cyc(2);
        up_scl = 1'b1; cyc(3);
        check("R10 scl high sda low", "link_en", link_en, 1'b0);
        up_sda = 1'b1;
        cyc(1);
        check("R10 sync latency", "link_en", link_en, 1'b0);
        cyc(3);
        check("R10 stop joins", "link_en", link_en, 1'b1);

        // R2 / R3: stop while other side busy, then idle with a glitch
        enable = 1'b0; cyc(1);
        up_scl = 1'b0; dn_scl = 1'b0;
        enable = 1'b1;
        cyc(40);
        stop_on(1'b0);
        cyc(6);
        check("R2 stop with busy side", "link_en", link_en, 1'b0);
        dn_scl = 1'b1; dn_sda = 1'b1;
        cyc(16);
        dn_sda = 1'b0; cyc(1); dn_sda = 1'b1;
        cyc(30);
        check("R3 glitch restarts idle", "link_en", link_en, 1'b0);
        cyc(10);
        check("R3 idle joins", "link_en", link_en, 1'b1);

        // R7 / R8 / R9: fault while linked
        stuck_fault = 1'b1;
        #1;
        check("R9 accel drops", "accel_en", accel_en, 1'b0);
        cyc(1);
        check_outs("R7 fault drop", 1'b0, 1'b0);
        dn_sda = 1'b0;
        cyc(50);
        stuck_fault = 1'b0;
        cyc(40);
        check("R8 rearm waits", "link_en", link_en, 1'b0);
        dn_sda = 1'b1;
        cyc(4);
        check_outs("R8 rejoin on stop", 1'b1, 1'b0);

        // Random rounds: enable pulse, noise, then a chosen boundary
        for (int r = 0; r < 20; r++) begin
            int kind;
            enable = 1'b0;
            cyc(1);
            check("R5 random enable low", "ready_pull", ready_pull, 1'b1);
            cyc($urandom_range(0, 4));
            enable = 1'b1;
            for (int j = 0; j < int'($urandom_range(30, 60)); j++) begin
                up_scl = 1'b0; dn_scl = 1'b0;
                up_sda = 1'($urandom()); dn_sda = 1'($urandom());
                cyc(1);
            end
            check("R2 random noise", "link_en", link_en, 1'b0);
            kind = int'($urandom_range(0, 2));
            if (kind == 0) begin
                up_scl = 1'b1; up_sda = 1'b1; dn_scl = 1'b1; dn_sda = 1'b1;
                cyc(28);
                check("R3 random idle early", "link_en", link_en, 1'b0);
                cyc(12);
            end else begin
                if (kind == 1) begin dn_scl = 1'b1; dn_sda = 1'b1; end
                else           begin up_scl = 1'b1; up_sda = 1'b1; end
                cyc(40);
                check("R2 random one idle", "link_en", link_en, 1'b0);
                stop_on(kind == 2);
                cyc(4);
            end
            check_outs("R2 random join", 1'b1, 1'b0);
        end

        // R1 / R4: power loss restores precharge, then rejoin
        pwr_good = 1'b0;
        cyc(1);
        check_outs("R1 power loss", 1'b0, 1'b1);
        cyc(5);
        pwr_good = 1'b1;
        cyc(40);
        check_outs("R4 rejoin after power", 1'b1, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule